// File: doc/BRIEF.md
# Endpoint descriptor chain walker

This block runs the control and bulk work queues of a host controller. Each queue is a chain of endpoint records in shared memory, and each endpoint holds a chain of transfer records. Software places the first endpoint address of each queue on two head inputs and pulses `start`. The walker then reads the endpoint records one 32-bit word per cycle. For each endpoint that has work, it fetches the first pending transfer record and presents that record's buffer bounds to an external transfer engine.

When the engine signals completion, the walker unlinks the record from its endpoint and pushes it onto a completion list. The completion list is a chain that is anchored in the `done_head` output. Each retirement is marked by a one-cycle event.

Passes over the two queues repeat while they keep finding work. The walker goes idle after the first pass that finds every endpoint empty.

Top module: `ed_list_walker`

## Requirements
- R1: While reset is held and in the cycles after it, `idle` is 1, `xfer_req` is 0, `done_evt` is 0 and `done_head` is 0.
- R2: An endpoint record at address E holds its tail transfer pointer at E+0x4, its head transfer pointer at E+0x8 and its next endpoint pointer at E+0xC. The control queue is walked from `ctrl_head` and the bulk queue from `bulk_head`.
- R3: A transfer record at address T holds its first buffer byte address at T+0x4, its next transfer pointer at T+0x8 and its last buffer byte address at T+0xC. A request shows these first and last addresses on `xfer_first` and `xfer_last`.
- R4: An endpoint whose masked head pointer equals its masked tail pointer is empty. No request is issued for it.
- R5: A next endpoint pointer of zero ends its queue. A queue whose head input is zero is not visited.
- R6: Within a pass, one endpoint is taken per turn, alternating between the queues and starting with control. Once one queue has ended, the other is taken on every turn.
- R7: At most one request is outstanding at a time. `xfer_req`, `xfer_first` and `xfer_last` stay unchanged until `xfer_done` is seen, and no memory access occurs while a request is open.
- R8: Retirement happens after `xfer_done` and uses the memory writes in this order. First, the endpoint head field (E+0x8) gets the record's next pointer. Second, the record's next field (T+0x8) gets the old `done_head`. Then `done_head` becomes T, and `done_evt` pulses high for one cycle.
- R9: The low four bits of the head inputs and of every fetched endpoint or transfer pointer are cleared before use.
- R10: A pass that issues a request is followed by a new pass from the head inputs. A pass that issues none returns to `idle`. `start` has no effect while the walker is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk when idle |
| ctrl_head | input | 32 | First endpoint of the control queue |
| bulk_head | input | 32 | First endpoint of the bulk queue |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| xfer_req | output | 1 | Transfer request open |
| xfer_first | output | 32 | First buffer byte address |
| xfer_last | output | 32 | Last buffer byte address |
| xfer_done | input | 1 | Engine finished the open request |
| done_head | output | 32 | Head of the completion chain |
| done_evt | output | 1 | One-cycle pulse per retired record |
| idle | output | 1 | No walk in progress |

## Verification
The walker is tried on four input patterns.

- A single endpoint with two queued records shows that one record is served per pass and that the passes repeat.
- Two control endpoints next to one bulk endpoint reveal the alternation order and the fall-back to the control queue once the bulk queue has ended.
- Pointers with stray low bits, together with an endpoint whose head equals its tail, separate correct masking from a wrong emptiness decision.
- A zero control head combined with a slow engine and a `start` pulse mid-transfer shows that the zero-headed queue is skipped, that the request outputs are held and that `start` is ignored while busy.

Memory contents and the `done_head` chain are compared with values worked out by hand after each pattern.

// File: rtl/ed_list_walker.sv
module ed_list_walker #(
  parameter int AW = 32,
  parameter int ALIGN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ctrl_head,
  input  logic [AW-1:0] bulk_head,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic          xfer_req,
  output logic [AW-1:0] xfer_first,
  output logic [AW-1:0] xfer_last,
  input  logic          xfer_done,
  output logic [AW-1:0] done_head,
  output logic          done_evt,
  output logic          idle
);
  localparam logic [AW-1:0] MASK = {{(AW-ALIGN){1'b1}}, {ALIGN{1'b0}}};

  typedef enum logic [3:0] {
    S_IDLE, S_PICK, S_ED_T, S_ED_H, S_ED_N, S_ED_W,
    S_TD_F, S_TD_N, S_TD_L, S_TD_W, S_XFER, S_RET1, S_RET2, S_RET3
  } st_t;

  st_t st;
  logic          turn, sel, found, c_end, b_end;
  logic [AW-1:0] c_cur, b_cur, ed, tail, td, td_next, first, last;
  logic [AW-1:0] rd_m;

  assign rd_m = mem_rdata & MASK;

  wire take_c = !c_end && (!turn || b_end);
  wire take_b = !b_end && !take_c;
  wire [AW-1:0] ch_m = ctrl_head & MASK;
  wire [AW-1:0] bh_m = bulk_head & MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      turn <= 1'b0; sel <= 1'b0; found <= 1'b0;
      c_end <= 1'b1; b_end <= 1'b1;
      c_cur <= '0; b_cur <= '0; ed <= '0; tail <= '0; td <= '0;
      td_next <= '0; first <= '0; last <= '0;
      done_head <= '0; done_evt <= 1'b0;
    end else begin
      done_evt <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          c_cur <= ch_m; b_cur <= bh_m;
          c_end <= (ch_m == '0); b_end <= (bh_m == '0);
          turn <= 1'b0; found <= 1'b0;
          st <= S_PICK;
        end
        S_PICK: begin
          if (take_c) begin
            ed <= c_cur; sel <= 1'b0; st <= S_ED_T;
          end else if (take_b) begin
            ed <= b_cur; sel <= 1'b1; st <= S_ED_T;
          end else if (found) begin
            c_cur <= ch_m; b_cur <= bh_m;
            c_end <= (ch_m == '0); b_end <= (bh_m == '0);
            turn <= 1'b0; found <= 1'b0;
          end else begin
            st <= S_IDLE;
          end
        end
        S_ED_T: st <= S_ED_H;
        S_ED_H: begin tail <= rd_m; st <= S_ED_N; end
        S_ED_N: begin td <= rd_m; st <= S_ED_W; end
        S_ED_W: begin
          if (sel) begin b_cur <= rd_m; b_end <= (rd_m == '0); end
          else     begin c_cur <= rd_m; c_end <= (rd_m == '0); end
          turn <= ~sel;
          st <= (td == tail) ? S_PICK : S_TD_F;
        end
        S_TD_F: st <= S_TD_N;
        S_TD_N: begin first <= mem_rdata; st <= S_TD_L; end
        S_TD_L: begin td_next <= rd_m; st <= S_TD_W; end
        S_TD_W: begin last <= mem_rdata; found <= 1'b1; st <= S_XFER; end
        S_XFER: if (xfer_done) st <= S_RET1;
        S_RET1: st <= S_RET2;
        S_RET2: st <= S_RET3;
        S_RET3: begin
          done_head <= td; done_evt <= 1'b1; st <= S_PICK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en = 1'b1;
    mem_we = 1'b0;
    mem_addr = '0;
    mem_wdata = '0;
    case (st)
      S_ED_T: mem_addr = ed | 'h4;
      S_ED_H: mem_addr = ed | 'h8;
      S_ED_N: mem_addr = ed | 'hC;
      S_TD_F: mem_addr = td | 'h4;
      S_TD_N: mem_addr = td | 'h8;
      S_TD_L: mem_addr = td | 'hC;
      S_RET1: begin mem_we = 1'b1; mem_addr = ed | 'h8; mem_wdata = td_next; end
      S_RET2: begin mem_we = 1'b1; mem_addr = td | 'h8; mem_wdata = done_head; end
      default: mem_en = 1'b0;
    endcase
  end

  assign xfer_req   = (st == S_XFER);
  assign xfer_first = first;
  assign xfer_last  = last;
  assign idle       = (st == S_IDLE);
endmodule

// File: rtl/ed_list_walker_chk.sv
module ed_list_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          xfer_req,
  input logic [AW-1:0] xfer_first,
  input logic [AW-1:0] xfer_last,
  input logic          xfer_done,
  input logic [AW-1:0] done_head,
  input logic          done_evt,
  input logic          idle
);
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_first) && $stable(xfer_last));
  p_no_mem_in_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !mem_en);
  p_retire_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done |=> mem_en && mem_we && mem_addr[3:0] == 4'h8);
  p_evt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !done_evt);
  p_head_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(done_head) |-> done_evt);
  p_head_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_head[3:0] == 4'h0);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !xfer_req && !mem_en);
endmodule

bind ed_list_walker ed_list_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
  .xfer_req(xfer_req), .xfer_first(xfer_first), .xfer_last(xfer_last),
  .xfer_done(xfer_done), .done_head(done_head), .done_evt(done_evt), .idle(idle)
);

// File: tb/ed_list_walker_tb.sv
module ed_list_walker_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, xfer_done = 1'b0;
  logic [31:0] ctrl_head = '0, bulk_head = '0;
  logic mem_en, mem_we, xfer_req, done_evt, idle;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, xfer_first, xfer_last, done_head;

  always #5 clk = ~clk;

  ed_list_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_head(ctrl_head), .bulk_head(bulk_head),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .xfer_req(xfer_req), .xfer_first(xfer_first),
    .xfer_last(xfer_last), .xfer_done(xfer_done), .done_head(done_head),
    .done_evt(done_evt), .idle(idle)
  );

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    else if (mem_en) mem_rdata <= mem[mem_addr[9:2]];
  end

  int nchk = 0, nfail = 0;
  int eng_delay = 0, wcnt = 0, nreq = 0, nevt = 0, nacc = 0;
  bit stab_bad = 0;
  logic [31:0] cap_f, cap_l;
  logic [31:0] lf [0:7];
  logic [31:0] ll [0:7];

  always @(negedge clk) begin
    if (mem_en) nacc++;
    if (done_evt) nevt++;
    if (xfer_req && !xfer_done) begin
      if (wcnt == 0) begin cap_f = xfer_first; cap_l = xfer_last; end
      else if (xfer_first !== cap_f || xfer_last !== cap_l) stab_bad = 1;
      if (wcnt == eng_delay) begin
        xfer_done = 1'b1;
        if (nreq < 8) begin lf[nreq] = xfer_first; ll[nreq] = xfer_last; end
        nreq++;
        wcnt = 0;
      end else wcnt++;
    end else xfer_done = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ceq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic put_ed(input int a, input logic [31:0] tl, input logic [31:0] hd, input logic [31:0] nx);
    mem[a/4] = 32'h0; mem[a/4+1] = tl; mem[a/4+2] = hd; mem[a/4+3] = nx;
  endtask

  task automatic put_td(input int a, input logic [31:0] f, input logic [31:0] nx, input logic [31:0] l);
    mem[a/4] = 32'h0; mem[a/4+1] = f; mem[a/4+2] = nx; mem[a/4+3] = l;
  endtask

  task automatic clear_log();
    nreq = 0; nevt = 0; nacc = 0; stab_bad = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && !idle; i++) @(negedge clk);
    chk(idle === 1'b1, "R10 walk returns to idle", {31'h0, idle}, 32'h1);
  endtask

  task automatic run_pass(input logic [31:0] ch, input logic [31:0] bh);
    ctrl_head = ch; bulk_head = bh;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    ceq("R1 idle after reset", {31'h0, idle}, 32'h1);
    ceq("R1 no request after reset", {31'h0, xfer_req}, 32'h0);
    ceq("R1 done_head cleared", done_head, 32'h0);
    ceq("R1 no event after reset", {31'h0, done_evt}, 32'h0);
  endtask

  task automatic t_one_ed_two_td();
    clear_log();
    put_ed('h100, 32'h180, 32'h140, 32'h0);
    put_td('h140, 32'h1000, 32'h160, 32'h103F);
    put_td('h160, 32'h2000, 32'h180, 32'h2007);
    run_pass(32'h100, 32'h0);
    ceq("R10 two passes give two requests", nreq, 2);
    ceq("R3 first req first addr", lf[0], 32'h1000);
    ceq("R3 first req last addr", ll[0], 32'h103F);
    ceq("R2 second req follows head", lf[1], 32'h2000);
    ceq("R3 second req last addr", ll[1], 32'h2007);
    ceq("R8 endpoint head advanced", mem['h108/4], 32'h180);
    ceq("R8 first retired links old done head", mem['h148/4], 32'h0);
    ceq("R8 second retired links first", mem['h168/4], 32'h140);
    ceq("R8 done_head is last retired", done_head, 32'h160);
    ceq("R8 one event per retirement", nevt, 2);
  endtask

  task automatic t_alternate();
    clear_log();
    put_ed('h200, 32'h2C0, 32'h240, 32'h210);
    put_ed('h210, 32'h2D0, 32'h260, 32'h0);
    put_ed('h220, 32'h2E0, 32'h280, 32'h0);
    put_td('h240, 32'h3000, 32'h2C0, 32'h30FF);
    put_td('h260, 32'h4000, 32'h2D0, 32'h4001);
    put_td('h280, 32'h5000, 32'h2E0, 32'h5555);
    run_pass(32'h200, 32'h220);
    ceq("R6 three requests", nreq, 3);
    ceq("R6 control endpoint first", lf[0], 32'h3000);
    ceq("R6 bulk endpoint second", lf[1], 32'h5000);
    ceq("R6 control resumes after bulk ends", lf[2], 32'h4000);
    ceq("R5 bulk end pointer honoured", ll[2], 32'h4001);
    ceq("R8 done chain head", done_head, 32'h260);
    ceq("R8 chain link 1", mem['h268/4], 32'h280);
    ceq("R8 chain link 2", mem['h288/4], 32'h240);
    ceq("R8 chain link 3", mem['h248/4], 32'h160);
    ceq("R8 bulk head advanced", mem['h228/4], 32'h2E0);
  endtask

  task automatic t_mask_empty();
    clear_log();
    put_ed('h300, 32'h3C0, 32'h3C2, 32'h319);
    put_ed('h310, 32'h3A0, 32'h383, 32'h0);
    put_td('h380, 32'h6000, 32'h3A1, 32'h600F);
    run_pass(32'h305, 32'h227);
    ceq("R4 empty endpoint skipped, one request", nreq, 1);
    ceq("R9 masked pointers reach record", lf[0], 32'h6000);
    ceq("R9 last address read", ll[0], 32'h600F);
    ceq("R9 written head is masked", mem['h318/4], 32'h3A0);
    ceq("R4 empty endpoint head untouched", mem['h308/4], 32'h3C2);
    ceq("R8 chain link", mem['h388/4], 32'h260);
    ceq("R9 done_head aligned", done_head, 32'h380);
  endtask

  task automatic t_zero_heads();
    clear_log();
    run_pass(32'h0, 32'h0);
    ceq("R5 zero heads give no request", nreq, 0);
    ceq("R5 zero heads give no memory access", nacc, 0);
    ceq("R5 done_head unchanged", done_head, 32'h380);
  endtask

  task automatic t_slow_engine();
    clear_log();
    eng_delay = 20;
    put_ed('h1C0, 32'h1F0, 32'h1E0, 32'h0);
    put_td('h1E0, 32'h7000, 32'h1F0, 32'h7FFF);
    ctrl_head = 32'h0; bulk_head = 32'h1C0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 200 && !xfer_req; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_idle();
    ceq("R7 request held stable", {31'h0, stab_bad}, 32'h0);
    ceq("R10 start while busy ignored", nreq, 1);
    ceq("R5 zero control head skipped", lf[0], 32'h7000);
    ceq("R8 done_head", done_head, 32'h1E0);
    ceq("R8 link to previous", mem['h1E8/4], 32'h380);
    eng_delay = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_ed_two_td();
    t_alternate();
    t_mask_empty();
    t_zero_heads();
    t_slow_engine();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule